// File: doc/BRIEF.md
# Accumulator Readout Converter

This block sits behind a multiply-accumulate unit and turns a 48-bit accumulator value into a word for a general register. One of three interpretations is chosen per request. Signed integer clamps the value into 32-bit two's complement. Unsigned integer clamps it to all-ones. Fractional drops guard bits, rounds half-to-even and optionally saturates, either to 32 bits or to a 16-bit storage format.

A request is presented with `valid_i` high for one cycle, together with the accumulator and the mode controls. All of these are captured at that clock edge. The converted word is registered and appears with `valid_o` one edge later. Between results, `result_o` keeps its last value.

Top module: `acc_readout`

## Requirements
- R1: `fmt_i` code 0 selects signed integer, code 1 selects unsigned integer, and codes 2 and 3 select fractional. A request sampled with `valid_i` high at clock edge k gives `valid_o` high for one cycle after edge k+1, with the converted word on `result_o`.
- R2: While no request is being delivered, `valid_o` is low and `result_o` holds its previous value, whatever the other inputs do.
- R3: Signed integer: when bits 47:31 of the accumulator are all equal, the result is accumulator bits 31:0.
- R4: Signed integer: otherwise the result is 0x7FFFFFFF when bit 47 is 0, and 0x80000000 when bit 47 is 1.
- R5: Unsigned integer: the result is bits 31:0 when bits 47:32 are zero, and 0xFFFFFFFF otherwise.
- R6: Fractional with `narrow_i` high: the kept value is bits 39:24 and the remainder is bits 23:0. Rounding is always applied, whatever `round_en_i` says. Bits 47:40 have no effect, and result bits 31:16 are zero.
- R7: Rounding adds one to the kept value when the remainder exceeds half of its range. When the remainder is exactly half, it adds the kept value's bit 0 (ties to even).
- R8: Fractional with `narrow_i` low and `round_en_i` high: the kept value is bits 47:8 and the remainder is bits 7:0, rounded as in R7.
- R9: Fractional with `narrow_i` and `round_en_i` both low: the result comes from bits 47:8, truncated.
- R10: Fractional with `sat_en_i` high: when the rounded value does not fit the storage width, the result is 0x7FFF for 16-bit storage and 0x7FFFFFFF for 32-bit storage. A value does not fit when it is 2^16 or more for 16-bit storage, or 2^32 or more for 32-bit storage.
- R11: Fractional with `sat_en_i` low: the result is the low 16 bits (zero-extended) or the low 32 bits of the rounded value.
- R12: While `rst_ni` is low, `valid_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe; captures the inputs below |
| acc_i | input | 48 | Accumulator value |
| fmt_i | input | 2 | Readout format: 0 signed, 1 unsigned, 2 or 3 fractional |
| round_en_i | input | 1 | Enables rounding for 32-bit fractional readout |
| sat_en_i | input | 1 | Enables saturation for fractional readout |
| narrow_i | input | 1 | Selects 16-bit storage for fractional readout |
| valid_o | output | 1 | Result strobe |
| result_o | output | 32 | Converted word |

## Verification
Directed values probe the edges of each path. For fractional readout these are remainders just below, exactly at and just above half, with even and odd kept values, which separates ties-to-even from plain round-half-up. Kept values of all ones with a rounding carry check that overflow is detected after rounding and not before. The integer values 0x7FFFFFFF, 0x80000000 and their negative mirrors sit exactly on each clamp boundary. Random accumulators across all mode combinations, with saturation on and off, are compared against a bench reference model, and idle cycles with changing inputs confirm that the output holds.

// File: rtl/acc_readout_pkg.sv
package acc_readout_pkg;
  typedef enum logic [1:0] {
    FMT_SINT  = 2'd0,
    FMT_UINT  = 2'd1,
    FMT_FRAC  = 2'd2,
    FMT_FRAC2 = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic rnd;
    logic sat;
    logic narrow;
  } mode_t;
endpackage

// File: rtl/acc_rne_round.sv
module acc_rne_round #(
  parameter int KEEP_W = 16,
  parameter int REM_W  = 24
) (
  input  logic [KEEP_W-1:0] keep_i,
  input  logic [REM_W-1:0]  rem_i,
  input  logic              en_i,
  output logic [KEEP_W:0]   sum_o
);
  localparam logic [REM_W-1:0] HALF = {1'b1, {(REM_W-1){1'b0}}};

  logic inc;
  always_comb begin
    inc = 1'b0;
    if (en_i) begin
      if (rem_i > HALF)       inc = 1'b1;
      else if (rem_i == HALF) inc = keep_i[0];
    end
    sum_o = {1'b0, keep_i} + {{KEEP_W{1'b0}}, inc};
  end
endmodule

// File: rtl/acc_frac_path.sv
module acc_frac_path #(
  parameter int ACC_W        = 48,
  parameter int OUT_W        = 32,
  parameter int NARROW_W     = 16,
  parameter int WIDE_SHIFT   = 8,
  parameter int NARROW_SHIFT = 24
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             rnd_i,
  input  logic             sat_i,
  input  logic             narrow_i,
  output logic [OUT_W-1:0] res_o
);
  localparam int WIDE_KW = ACC_W - WIDE_SHIFT;
  localparam logic [OUT_W-1:0] WIDE_MAX   = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NARROW_MAX = {{(OUT_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};

  logic [WIDE_KW:0]  wide_sum;
  logic [NARROW_W:0] narrow_sum;
  logic              wide_ovf;

  acc_rne_round #(.KEEP_W(WIDE_KW), .REM_W(WIDE_SHIFT)) u_rnd_wide (
    .keep_i (acc_i[ACC_W-1:WIDE_SHIFT]),
    .rem_i  (acc_i[WIDE_SHIFT-1:0]),
    .en_i   (rnd_i),
    .sum_o  (wide_sum)
  );

  // narrow storage always rounds
  acc_rne_round #(.KEEP_W(NARROW_W), .REM_W(NARROW_SHIFT)) u_rnd_narrow (
    .keep_i (acc_i[NARROW_SHIFT+NARROW_W-1:NARROW_SHIFT]),
    .rem_i  (acc_i[NARROW_SHIFT-1:0]),
    .en_i   (1'b1),
    .sum_o  (narrow_sum)
  );

  assign wide_ovf = |wide_sum[WIDE_KW:OUT_W];

  always_comb begin
    if (narrow_i) begin
      if (sat_i && narrow_sum[NARROW_W]) res_o = NARROW_MAX;
      else res_o = {{(OUT_W-NARROW_W){1'b0}}, narrow_sum[NARROW_W-1:0]};
    end else begin
      if (sat_i && wide_ovf) res_o = WIDE_MAX;
      else res_o = wide_sum[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/acc_int_path.sv
module acc_int_path #(
  parameter int ACC_W = 48,
  parameter int OUT_W = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             is_signed_i,
  output logic [OUT_W-1:0] res_o
);
  localparam logic [OUT_W-1:0] S_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] S_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic s_fit, u_fit;
  assign s_fit = (&acc_i[ACC_W-1:OUT_W-1]) | ~(|acc_i[ACC_W-1:OUT_W-1]);
  assign u_fit = ~(|acc_i[ACC_W-1:OUT_W]);

  always_comb begin
    if (is_signed_i) begin
      if (s_fit) res_o = acc_i[OUT_W-1:0];
      else       res_o = acc_i[ACC_W-1] ? S_MIN : S_MAX;
    end else begin
      res_o = u_fit ? acc_i[OUT_W-1:0] : {OUT_W{1'b1}};
    end
  end
endmodule

// File: rtl/acc_readout.sv
module acc_readout
  import acc_readout_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [1:0]       fmt_i,
  input  logic             round_en_i,
  input  logic             sat_en_i,
  input  logic             narrow_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] result_o
);
  logic             v_q;
  logic [ACC_W-1:0] acc_q;
  mode_t            mode_q;
  logic [OUT_W-1:0] int_res, frac_res, sel_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      acc_q  <= '0;
      mode_q <= '{fmt: FMT_SINT, rnd: 1'b0, sat: 1'b0, narrow: 1'b0};
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        acc_q  <= acc_i;
        mode_q <= '{fmt: fmt_e'(fmt_i), rnd: round_en_i, sat: sat_en_i, narrow: narrow_i};
      end
    end
  end

  acc_int_path #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_int (
    .acc_i       (acc_q),
    .is_signed_i (mode_q.fmt == FMT_SINT),
    .res_o       (int_res)
  );

  acc_frac_path #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_frac (
    .acc_i    (acc_q),
    .rnd_i    (mode_q.rnd),
    .sat_i    (mode_q.sat),
    .narrow_i (mode_q.narrow),
    .res_o    (frac_res)
  );

  assign sel_res = mode_q.fmt[1] ? frac_res : int_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= v_q;
      if (v_q) result_o <= sel_res;
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 2));

  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));

  assert_sint_pos_clamp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_q.fmt) == FMT_SINT && !$past(acc_q[ACC_W-1])
     && $past(|acc_q[ACC_W-2:OUT_W-1])) |-> result_o == {1'b0, {(OUT_W-1){1'b1}}});

  assert_uint_clamp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_q.fmt) == FMT_UINT && $past(|acc_q[ACC_W-1:OUT_W]))
    |-> result_o == {OUT_W{1'b1}});

  assert_narrow_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_q.fmt[1]) && $past(mode_q.narrow)) |-> result_o[OUT_W-1:16] == '0);
endmodule

// File: tb/acc_readout_tb.sv
module acc_readout_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [47:0] acc_i = '0;
  logic [1:0]  fmt_i = '0;
  logic        round_en_i = 1'b0, sat_en_i = 1'b0, narrow_i = 1'b0;
  logic        valid_o;
  logic [31:0] result_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  acc_readout u_dut (.*);

  function automatic logic [31:0] ref_model(logic [47:0] a, logic [1:0] f,
                                            logic r, logic s, logic n);
    longint     sv;
    logic [63:0] v, rem;
    if (f == 2'd0) begin
      sv = longint'($signed(a));
      if (sv > 64'sd2147483647)  return 32'h7FFF_FFFF;
      if (sv < -64'sd2147483648) return 32'h8000_0000;
      return sv[31:0];
    end
    if (f == 2'd1) return (a >= 48'h1_0000_0000) ? 32'hFFFF_FFFF : a[31:0];
    if (n) begin
      v   = ({16'h0, a} >> 24) & 64'hFFFF;
      rem = {16'h0, a} & 64'hFF_FFFF;
      if (rem > 64'h80_0000) v = v + 1;
      else if (rem == 64'h80_0000) v = v + (v & 1);
      if (v > 64'hFFFF && s) return 32'h7FFF;
      return {16'h0, v[15:0]};
    end
    v = {16'h0, a} >> 8;
    if (r) begin
      rem = {16'h0, a} & 64'hFF;
      if (rem > 64'h80) v = v + 1;
      else if (rem == 64'h80) v = v + (v & 1);
    end
    if (v > 64'hFFFF_FFFF && s) return 32'h7FFF_FFFF;
    return v[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_one(string tag, logic [47:0] a, logic [1:0] f,
                         logic r, logic s, logic n);
    @(negedge clk_i);
    acc_i = a; fmt_i = f; round_en_i = r; sat_en_i = s; narrow_i = n; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    acc_i = ~a;
    @(negedge clk_i);
    check({tag, " valid (R1)"}, {31'h0, valid_o}, 32'h1);
    check(tag, result_o, ref_model(a, f, r, s, n));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R12 valid", {31'h0, valid_o}, 32'h0);
    check("R12 result", result_o, 32'h0);
    rst_ni = 1'b1;

    // signed integer
    run_one("R3", 48'h0000_7FFF_FFFF, 2'd0, 0, 0, 0);
    run_one("R3", 48'hFFFF_8000_0000, 2'd0, 0, 0, 0);
    run_one("R3", 48'hFFFF_FFFF_FFFE, 2'd0, 0, 0, 0);
    run_one("R4", 48'h0000_8000_0000, 2'd0, 0, 0, 0);
    run_one("R4", 48'hFFFF_7FFF_FFFF, 2'd0, 0, 0, 0);
    run_one("R4", 48'h8000_0000_0000, 2'd0, 0, 0, 0);
    // unsigned integer
    run_one("R5", 48'h0000_FFFF_FFFF, 2'd1, 0, 0, 0);
    run_one("R5", 48'h0001_0000_0000, 2'd1, 0, 0, 0);
    run_one("R5", 48'h8000_0000_0001, 2'd1, 0, 0, 0);
    // narrow fractional
    run_one("R6", 48'hAB00_0300_0000, 2'd2, 0, 0, 1);
    run_one("R7", 48'h0000_0180_0000, 2'd2, 0, 0, 1);
    run_one("R7", 48'h0000_0280_0000, 2'd3, 0, 0, 1);
    run_one("R7", 48'h0000_027F_FFFF, 2'd2, 0, 0, 1);
    run_one("R7", 48'h0000_0280_0001, 2'd2, 0, 0, 1);
    run_one("R10", 48'h00FF_FF80_0001, 2'd2, 0, 1, 1);
    run_one("R11", 48'h00FF_FF80_0001, 2'd2, 0, 0, 1);
    // wide fractional
    run_one("R8", 48'h0000_0000_0180, 2'd2, 1, 0, 0);
    run_one("R8", 48'h0000_0000_0280, 2'd2, 1, 0, 0);
    run_one("R8", 48'h0000_0000_0281, 2'd2, 1, 0, 0);
    run_one("R9", 48'h0000_0000_02FF, 2'd2, 0, 0, 0);
    run_one("R10", 48'h00FF_FFFF_FFFF, 2'd2, 1, 1, 0);
    run_one("R11", 48'h00FF_FFFF_FFFF, 2'd2, 1, 0, 0);
    run_one("R10", 48'h0100_0000_0000, 2'd2, 0, 1, 0);
    run_one("R11", 48'h0123_4567_89AB, 2'd2, 0, 0, 0);

    // idle hold
    held = result_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      acc_i = {$urandom, $urandom}; fmt_i = 2'($urandom); sat_en_i = ~sat_en_i;
      check("R2 valid", {31'h0, valid_o}, 32'h0);
      check("R2 hold", result_o, held);
    end

    // random
    for (int i = 0; i < 600; i++) begin
      logic [47:0] a;
      logic [1:0]  f;
      logic [2:0]  m;
      a = {16'($urandom), $urandom};
      if ($urandom_range(0, 3) == 0) a[47:32] = {16{a[31]}};
      f = 2'($urandom);
      m = 3'($urandom);
      if (f == 2'd0)      run_one("R3 R4 random", a, f, m[0], m[1], m[2]);
      else if (f == 2'd1) run_one("R5 random", a, f, m[0], m[1], m[2]);
      else if (m[2])      run_one("R6 random", a, f, m[0], m[1], m[2]);
      else                run_one("R8 R9 R10 R11 random", a, f, m[0], m[1], m[2]);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule